// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary32 floating-point operands. It sets the result sign to the XOR of the two operand signs. It adds the unbiased exponents. It multiplies the two 24-bit significands, each with its implicit leading one restored, into a 48-bit product. It then normalizes that product and rounds it to nearest, ties to even. Subnormal operands are accepted and are normalized before the multiply. Subnormal results are produced with correct rounding.

The interface is a single pulse. The caller presents `a_i` and `b_i` with `start_i` high for one cycle. Two cycles later `done_o` pulses for one cycle, and `result_o` carries the product. The block is a two-stage pipeline, so a new operation may start on every cycle. `result_o` keeps the last product until the next one completes.

Top module: `fpm_mul`

## Requirements
- R1: The result sign (bit 31) is the XOR of the operand signs. This holds for zero, subnormal, normal and infinite results, but not for NaN.
- R2: For normal operands whose product stays in range, the biased result exponent (bits 30:23) is the sum of the biased operand exponents minus 127. The fraction (bits 22:0) comes from the product of the significands with the hidden one restored.
- R3: When the significand product is 2.0 or more, the product is shifted right by one place and the exponent is raised by one.
- R4: Rounding is to nearest. Bits below the kept 24 supply the guard bit and the OR of all lower bits. An exact tie rounds to the value whose fraction LSB is 0.
- R5: A round-up that carries out of the fraction raises the exponent by one and leaves a zero fraction.
- R6: A result whose biased exponent would exceed 254, before or after rounding, becomes infinity (exponent 255, fraction 0) with the sign from R1.
- R7: Subnormal operands (exponent field 0, fraction nonzero) take the value fraction × 2^-149 and are multiplied exactly like normal operands.
- R8: Results below the normal range are written as subnormals (exponent field 0) and rounded as in R4. A result that rounds below the smallest subnormal becomes a zero with the sign from R1.
- R9: Any NaN operand, and zero times infinity in either order, give 0x7FC00000. Otherwise an infinite operand gives infinity and a zero operand gives zero.
- R10: `done_o` is high in exactly the cycle that is two clock edges after the edge that sampled `start_i` high. `start_i` may be high on consecutive cycles, and each product appears in its own `done_o` cycle.
- R11: `result_o` does not change in any cycle where `done_o` is low.
- R12: While `rst_ni` is low, `done_o` is 0 and `result_o` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operands valid; starts one multiplication |
| a_i | input | 32 | First operand, binary32 |
| b_i | input | 32 | Second operand, binary32 |
| done_o | output | 1 | One-cycle pulse when `result_o` holds a new product |
| result_o | output | 32 | Product, binary32, held between completions |

## Verification
The pipeline can capture a new operand pair in the same cycle that it rounds the previous pair and registers the result. The bench provokes this by holding `start_i` high on two consecutive cycles with operands of different classes: a rounding tie followed by a plain normal product. In each of the two following `done_o` cycles it checks that the expected product appears with no mixing of signs, exponents or special-value decisions between the two. It then checks that the second result is still held one cycle later. A start issued just before reset is also checked, to confirm that no completion leaks out of reset.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {CLS_ZERO, CLS_FINITE, CLS_INF, CLS_NAN} op_cls_e;
  typedef enum logic [1:0] {KIND_NUM, KIND_ZERO, KIND_INF, KIND_NAN} res_kind_e;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int XW = EXP_W + 3
) (
  input  logic [W-1:0]           op_i,
  output logic                   sign_o,
  output fpm_pkg::op_cls_e       cls_o,
  output logic signed [XW-1:0]   exp_o,
  output logic [SIG_W-1:0]       sig_o
);
  localparam int LZ_W = $clog2(SIG_W) + 1;

  logic [EXP_W-1:0] e_raw, e_eff;
  logic [MAN_W-1:0] f_raw;
  logic [SIG_W-1:0] raw_sig;
  logic [LZ_W-1:0]  lz;
  logic             found, e_zero, e_ones, f_zero;

  assign e_raw  = op_i[W-2 -: EXP_W];
  assign f_raw  = op_i[MAN_W-1:0];
  assign e_zero = ~|e_raw;
  assign e_ones = &e_raw;
  assign f_zero = ~|f_raw;
  assign sign_o = op_i[W-1];

  always_comb begin
    if (e_ones)      cls_o = f_zero ? fpm_pkg::CLS_INF : fpm_pkg::CLS_NAN;
    else if (e_zero) cls_o = f_zero ? fpm_pkg::CLS_ZERO : fpm_pkg::CLS_FINITE;
    else             cls_o = fpm_pkg::CLS_FINITE;
  end

  // subnormals: count leading zeros and renormalize so the MSB is set
  always_comb begin
    raw_sig = {~e_zero, f_raw};
    e_eff   = e_zero ? EXP_W'(1) : e_raw;
    lz      = '0;
    found   = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!found && raw_sig[i]) begin
        lz    = LZ_W'(SIG_W - 1 - i);
        found = 1'b1;
      end
    end
    sig_o = raw_sig << lz;
    exp_o = $signed({{(XW-EXP_W){1'b0}}, e_eff}) - $signed({{(XW-LZ_W){1'b0}}, lz});
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int PW = 2 * SIG_W,
  localparam int XW = EXP_W + 3
) (
  input  logic                  sign_i,
  input  fpm_pkg::res_kind_e    kind_i,
  input  logic [PW-1:0]         prod_i,
  input  logic signed [XW-1:0]  exp_i,
  output logic [W-1:0]          res_o
);
  localparam int SH_W = $clog2(PW + 1) + 1;
  localparam logic signed [XW-1:0] ONE    = XW'(1);
  localparam logic signed [XW-1:0] PW_S   = XW'(PW);
  localparam logic signed [XW-1:0] EMAX_S = XW'((1 << EXP_W) - 2);

  logic [PW-1:0]         v, v_sh;
  logic signed [XW-1:0]  e, depth;
  logic [SH_W-1:0]       sh;
  logic                  lost, grd, stk, up;
  logic [EXP_W-1:0]      efield;
  logic [EXP_W+MAN_W-1:0] body;

  always_comb begin
    // leading one to bit PW-1; a product in [2,4) bumps the exponent
    if (prod_i[PW-1]) begin
      v = prod_i;
      e = exp_i + ONE;
    end else begin
      v = prod_i << 1;
      e = exp_i;
    end
    depth = ONE - e;
    if (e >= ONE)        sh = '0;
    else if (depth > PW_S) sh = SH_W'(PW);
    else                 sh = depth[SH_W-1:0];
    v_sh = v >> sh;
    lost = |(v & ~({PW{1'b1}} << sh));
    grd  = v_sh[PW-1-SIG_W];
    stk  = (|v_sh[PW-2-SIG_W:0]) | lost;
    up   = grd & (stk | v_sh[PW-SIG_W]);
    efield = v_sh[PW-1] ? e[EXP_W-1:0] : '0;
    // carry from fraction ripples into the exponent field
    body = {efield, v_sh[PW-2 -: MAN_W]} + (EXP_W+MAN_W)'(up);
    unique case (kind_i)
      fpm_pkg::KIND_NAN:  res_o = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
      fpm_pkg::KIND_INF:  res_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      fpm_pkg::KIND_ZERO: res_o = {sign_i, {(W-1){1'b0}}};
      default: begin
        if (e > EMAX_S) res_o = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        else            res_o = {sign_i, body};
      end
    endcase
  end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic          done_o,
  output logic [W-1:0]  result_o
);
  localparam int SIG_W = MAN_W + 1;
  localparam int PW    = 2 * SIG_W;
  localparam int XW    = EXP_W + 3;
  localparam logic signed [XW-1:0] BIAS = XW'((1 << (EXP_W - 1)) - 1);

  logic [W-1:0]          ops  [2];
  logic                  sgn  [2];
  fpm_pkg::op_cls_e      cls  [2];
  logic signed [XW-1:0]  xp   [2];
  logic [SIG_W-1:0]      sig  [2];

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpm_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .op_i  (ops[g]),
      .sign_o(sgn[g]),
      .cls_o (cls[g]),
      .exp_o (xp[g]),
      .sig_o (sig[g])
    );
  end

  fpm_pkg::res_kind_e kind_d, s1_kind;
  logic               any_nan, any_inf, any_zero;
  logic               s1_vld, s1_sign;
  logic [PW-1:0]      s1_prod;
  logic signed [XW-1:0] s1_exp;
  logic [W-1:0]       rnd_res;

  always_comb begin
    any_nan  = (cls[0] == fpm_pkg::CLS_NAN)  || (cls[1] == fpm_pkg::CLS_NAN);
    any_inf  = (cls[0] == fpm_pkg::CLS_INF)  || (cls[1] == fpm_pkg::CLS_INF);
    any_zero = (cls[0] == fpm_pkg::CLS_ZERO) || (cls[1] == fpm_pkg::CLS_ZERO);
    if (any_nan || (any_inf && any_zero)) kind_d = fpm_pkg::KIND_NAN;
    else if (any_inf)                      kind_d = fpm_pkg::KIND_INF;
    else if (any_zero)                     kind_d = fpm_pkg::KIND_ZERO;
    else                                   kind_d = fpm_pkg::KIND_NUM;
  end

  // stage 1: classify, add exponents (bias removed once), multiply significands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_sign <= 1'b0;
      s1_kind <= fpm_pkg::KIND_ZERO;
      s1_prod <= '0;
      s1_exp  <= '0;
    end else begin
      s1_vld <= start_i;
      if (start_i) begin
        s1_sign <= sgn[0] ^ sgn[1];
        s1_kind <= kind_d;
        s1_prod <= PW'(sig[0]) * PW'(sig[1]);
        s1_exp  <= xp[0] + xp[1] - BIAS;
      end
    end
  end

  fpm_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
    .sign_i(s1_sign),
    .kind_i(s1_kind),
    .prod_i(s1_prod),
    .exp_i (s1_exp),
    .res_o (rnd_res)
  );

  // stage 2: normalize, round, register result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= s1_vld;
      if (s1_vld) result_o <= rnd_res;
    end
  end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [1:0] age_q;
  logic       res_nan;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign res_nan = (&result_o[W-2 -: EXP_W]) && (|result_o[MAN_W-1:0]);

  AST_DONE_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##2 done_o); // R10

  AST_DONE_HAS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && age_q == 2'd3) |-> $past(start_i, 2)); // R10

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R11

  AST_NAN_CANONICAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && res_nan) |-> (result_o == QNAN)); // R9

  AST_SIGN_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !res_nan && age_q == 2'd3) |->
      (result_o[W-1] == $past(a_i[W-1] ^ b_i[W-1], 2))); // R1
endmodule

bind fpm_mul fpm_mul_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fpm_mul_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .done_o  (done_o),
  .result_o(result_o)
);

// File: tb/fpm_mul_test.sv
module fpm_mul_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        done_o;
  logic [31:0] result_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i; // 125 MHz

  fpm_mul uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .done_o(done_o), .result_o(result_o)
  );

  localparam int NV = 30;
  // {a, b, expected}
  localparam logic [95:0] VEC [NV] = '{
    {32'h40000000, 32'h40400000, 32'h40C00000}, // R2 2*3
    {32'hBFC00000, 32'h40200000, 32'hC0700000}, // R1 -1.5*2.5
    {32'h3F800000, 32'h3F800000, 32'h3F800000}, // R2 1*1
    {32'h3FC00000, 32'h3FC00000, 32'h40100000}, // R3 1.5*1.5
    {32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE}, // R3 [2,4) with sticky
    {32'h3F800001, 32'h3FC00000, 32'h3FC00002}, // R4 tie, odd -> up
    {32'h3F800003, 32'h3FC00000, 32'h3FC00004}, // R4 tie, even -> stay
    {32'h3F800003, 32'h3FC00001, 32'h3FC00006}, // R4 above half
    {32'h3F800001, 32'h3F800001, 32'h3F800002}, // R4 below half
    {32'h3FFFFFFE, 32'h3F800001, 32'h40000000}, // R5 carry into exponent
    {32'h7F000000, 32'h40000000, 32'h7F800000}, // R6 overflow
    {32'hFF000000, 32'h40000000, 32'hFF800000}, // R6 negative overflow
    {32'h7F7FFFFE, 32'h3F800001, 32'h7F800000}, // R6 overflow by rounding
    {32'h00000001, 32'h4B000000, 32'h00800000}, // R7 min subnormal operand
    {32'h00400000, 32'h40800000, 32'h01000000}, // R7 subnormal operand
    {32'h00800000, 32'h3F000000, 32'h00400000}, // R8 subnormal result
    {32'h00800000, 32'h34000000, 32'h00000001}, // R8 min subnormal result
    {32'h00800000, 32'h33800000, 32'h00000000}, // R8 half of min, tie to zero
    {32'h00800000, 32'h33C00000, 32'h00000001}, // R8 above half of min
    {32'h80800000, 32'h33800000, 32'h80000000}, // R8 signed zero
    {32'h00FFFFFF, 32'h3F000000, 32'h00800000}, // R8 rounds into normal
    {32'h00000001, 32'h00000001, 32'h00000000}, // R8 deep underflow
    {32'h00000000, 32'h40A00000, 32'h00000000}, // R9 zero
    {32'h80000000, 32'h40A00000, 32'h80000000}, // R1 negative zero
    {32'hFF800000, 32'hC0000000, 32'h7F800000}, // R9 inf
    {32'h00000000, 32'h7F800000, 32'h7FC00000}, // R9 zero*inf
    {32'h7F800001, 32'h3F800000, 32'h7FC00000}, // R9 NaN operand
    {32'h7F800000, 32'h80000001, 32'hFF800000}, // R1 inf*neg subnormal
    {32'h00000000, 32'h00000001, 32'h00000000}, // R9 zero*subnormal
    {32'hFFC00000, 32'hFF800000, 32'h7FC00000}  // R9 NaN*inf
  };
  localparam int VREQ [NV] = '{2, 1, 2, 3, 3, 4, 4, 4, 4, 5, 6, 6, 6, 7, 7,
                               8, 8, 8, 8, 8, 8, 8, 9, 1, 9, 9, 9, 1, 9, 9};

  task automatic check(input logic [31:0] act, input logic [31:0] exp_v,
                       input int req, input string what);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp_v);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp_v, input int req);
    @(negedge clk_i);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    check({31'd0, done_o}, 32'd1, 10, "done after two edges");
    check(result_o, exp_v, req, $sformatf("%h*%h", a, b));
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R12: reset state, with a start issued during reset
    start_i = 1'b1; a_i = 32'h40000000; b_i = 32'h40000000;
    repeat (3) @(negedge clk_i);
    check({31'd0, done_o}, 32'd0, 12, "done in reset");
    check(result_o, 32'h0, 12, "result in reset");
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check({31'd0, done_o}, 32'd0, 12, "no completion out of reset");

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], VREQ[i]);

    // R10: back-to-back starts, tie rounding then plain product
    @(negedge clk_i);
    a_i = 32'h3F800001; b_i = 32'h3FC00000; start_i = 1'b1;
    @(negedge clk_i);
    a_i = 32'hBFC00000; b_i = 32'h40200000;
    @(negedge clk_i);
    start_i = 1'b0; a_i = 32'h7F800000; b_i = 32'h00000000;
    check({31'd0, done_o}, 32'd1, 10, "first back-to-back done");
    check(result_o, 32'h3FC00002, 10, "first back-to-back result");
    @(negedge clk_i);
    check({31'd0, done_o}, 32'd1, 10, "second back-to-back done");
    check(result_o, 32'hC0700000, 10, "second back-to-back result");
    // R11: held while idle, inputs changing
    @(negedge clk_i);
    check({31'd0, done_o}, 32'd0, 11, "done single pulse");
    check(result_o, 32'hC0700000, 11, "result held");
    repeat (4) @(negedge clk_i);
    check(result_o, 32'hC0700000, 11, "result still held");

    // R12: reset while an operation is in flight
    a_i = 32'h40000000; b_i = 32'h40400000; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    check({31'd0, done_o}, 32'd0, 12, "done cleared by reset");
    check(result_o, 32'h0, 12, "result cleared by reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check({31'd0, done_o}, 32'd0, 12, "flushed op does not complete");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule